// File: doc/BRIEF.md
# Memory Access Alignment Checker

This block sits between a load/store unit and the memory interface and judges every access request against the alignment policy that two control bits select. The bit `mode_u_i` picks between legacy alignment (0) and unaligned-capable operation (1). The bit `strict_a_i` turns on strict fault checking. The verdict depends on these two bits, the access size and whether the access is exclusive. Exclusive accesses always keep natural alignment, even when unaligned operation is enabled.

Each request presented with `valid_i` high gets a registered result on the next clock. The result carries a verdict (allowed, allowed as unaligned, or alignment fault), a separate flag for a doubleword pair whose outcome is architecturally undefined, and a 3-bit cause code. The block does not split accesses into bus beats, does not rotate data, and does not model memory. Alignment is judged from the three low address bits, masked by the access size.

Top module: `align_chk`

## Requirements
- R1: While `rst_ni` is low, and on the first clock after it rises with `valid_i` low, `res_valid_o` is 0.
- R2: `res_valid_o` on a clock edge equals `valid_i` sampled on that edge. The verdict, flag and cause belong to the request sampled on the same edge.
- R3: A request is aligned when `addr_i[2:0]` AND (2^size − 1) is zero, where size encodes byte=0, halfword=1, word=2, doubleword=3. An aligned request gives verdict 0 (allowed), `res_unpred_o`=0 and cause 0 (none), for any `mode_u_i`, `strict_a_i` and `excl_i`.
- R4: A byte access (size 0) never faults. It always gives verdict 0 and cause 0.
- R5: A misaligned exclusive access of size halfword, word or doubleword gives verdict 2 (fault) and cause 3 (exclusive), whatever the values of `mode_u_i` and `strict_a_i`.
- R6: With `mode_u_i`=1, a misaligned non-exclusive halfword or word gives verdict 1 (allowed unaligned) and cause 1 (unaligned-ok).
- R7: With `mode_u_i`=0 and `strict_a_i`=1, a misaligned non-exclusive halfword or word gives verdict 2 and cause 2 (alignment).
- R8: With `mode_u_i`=0 and `strict_a_i`=0, a misaligned non-exclusive halfword or word gives verdict 0 and cause 0.
- R9: A non-exclusive doubleword that is not 8-byte aligned, with `strict_a_i`=1, gives verdict 2 and cause 2 for either value of `mode_u_i`. This includes word-aligned addresses such as low bits 4.
- R10: A non-exclusive doubleword that is not 8-byte aligned, with `strict_a_i`=0, gives verdict 0, `res_unpred_o`=1 and cause 4 (unpredictable), for either value of `mode_u_i`. `res_unpred_o` is 1 in no other case.
- R11: Address bits above bit 2 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request strobe |
| addr_i | input | ADDR_W | Byte address of the access |
| size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 doubleword |
| excl_i | input | 1 | Exclusive access |
| mode_u_i | input | 1 | 1 selects unaligned-capable operation |
| strict_a_i | input | 1 | 1 selects strict alignment faulting |
| res_valid_o | output | 1 | Result valid, one cycle after the request |
| res_verdict_o | output | 2 | 0 allowed, 1 allowed unaligned, 2 fault |
| res_unpred_o | output | 1 | Misaligned doubleword passed without a check |
| res_cause_o | output | 3 | 0 none, 1 unaligned-ok, 2 alignment, 3 exclusive, 4 unpredictable |

## Verification
Every result sits behind exactly one register, so the outcome of a request driven before edge N appears on the outputs after edge N. The bench changes its inputs on falling edges and reads the outputs on the next falling edge, which is half a period after the edge that captured the request. A vector table covers every size and mode combination with misaligned addresses, and each vector carries random upper address bits. Directed steps then check reset, the drop of `res_valid_o` when no request is present, and the upper-bit independence of R11.

// File: rtl/align_chk_pkg.sv
package align_chk_pkg;
  localparam int MAX_BYTES = 8;
  localparam int LOW_W     = $clog2(MAX_BYTES);

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [1:0] SZ_DBL  = 2'd3;

  typedef enum logic [1:0] {
    VD_ALLOW   = 2'd0,
    VD_UNALIGN = 2'd1,
    VD_FAULT   = 2'd2
  } verdict_e;

  typedef enum logic [2:0] {
    CS_NONE    = 3'd0,
    CS_UNAL_OK = 3'd1,
    CS_ALIGN   = 3'd2,
    CS_EXCL    = 3'd3,
    CS_UNPRED  = 3'd4
  } cause_e;

  typedef struct packed {
    verdict_e verdict;
    logic     unpred;
    cause_e   cause;
  } result_t;
endpackage

// File: rtl/align_chk_decode.sv
module align_chk_decode
  import align_chk_pkg::*;
(
  input  logic [LOW_W-1:0] addr_lo_i,
  input  logic [1:0]       size_i,
  input  logic             excl_i,
  input  logic             mode_u_i,
  input  logic             strict_a_i,
  output result_t          res_o
);
  logic [LOW_W-1:0] size_mask;
  logic             mis;

  // mask of address bits that must be zero for natural alignment
  always_comb begin
    size_mask = '0;
    for (int b = 0; b < LOW_W; b++) begin
      size_mask[b] = (b < int'(size_i));
    end
  end

  assign mis = |(addr_lo_i & size_mask);

  always_comb begin
    res_o = '{verdict: VD_ALLOW, unpred: 1'b0, cause: CS_NONE};
    if (mis) begin
      if (excl_i) begin
        res_o.verdict = VD_FAULT;
        res_o.cause   = CS_EXCL;
      end else if (size_i == SZ_DBL) begin
        if (strict_a_i) begin
          res_o.verdict = VD_FAULT;
          res_o.cause   = CS_ALIGN;
        end else begin
          res_o.unpred = 1'b1;
          res_o.cause  = CS_UNPRED;
        end
      end else if (mode_u_i) begin
        res_o.verdict = VD_UNALIGN;
        res_o.cause   = CS_UNAL_OK;
      end else if (strict_a_i) begin
        res_o.verdict = VD_FAULT;
        res_o.cause   = CS_ALIGN;
      end
    end
  end
endmodule

// File: rtl/align_chk_reg.sv
module align_chk_reg
  import align_chk_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    valid_i,
  input  result_t res_i,
  output logic    valid_o,
  output result_t res_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '{verdict: VD_ALLOW, unpred: 1'b0, cause: CS_NONE};
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_o <= res_i;
    end
  end
endmodule

// File: rtl/align_chk.sv
module align_chk
  import align_chk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              excl_i,
  input  logic              mode_u_i,
  input  logic              strict_a_i,
  output logic              res_valid_o,
  output logic [1:0]        res_verdict_o,
  output logic              res_unpred_o,
  output logic [2:0]        res_cause_o
);
  result_t dec_res;
  result_t q_res;

  align_chk_decode u_dec (
    .addr_lo_i (addr_i[LOW_W-1:0]),
    .size_i    (size_i),
    .excl_i    (excl_i),
    .mode_u_i  (mode_u_i),
    .strict_a_i(strict_a_i),
    .res_o     (dec_res)
  );

  align_chk_reg u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .res_i  (dec_res),
    .valid_o(res_valid_o),
    .res_o  (q_res)
  );

  assign res_verdict_o = q_res.verdict;
  assign res_unpred_o  = q_res.unpred;
  assign res_cause_o   = q_res.cause;

  AST_RESULT_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> res_valid_o); // R2
  AST_IDLE_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !res_valid_o); // R2
  AST_BYTE_NO_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == SZ_BYTE) |=> (res_verdict_o != 2'd2)); // R4
  AST_EXCL_ODD_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && excl_i && addr_i[0] && size_i != SZ_BYTE)
      |=> (res_verdict_o == 2'd2 && res_cause_o == 3'd3)); // R5
  AST_UNPRED_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_unpred_o) |-> (res_cause_o == 3'd4 && res_verdict_o == 2'd0)); // R10
endmodule

// File: tb/sim_align_chk.sv
module sim_align_chk;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int NV         = 18;

  // {u, a, excl, size[1:0], addr_lo[2:0], verdict[1:0], unpred, cause[2:0]}
  localparam logic [13:0] VEC [NV] = '{
    14'b0_0_0_11_000_00_0_000, // R3 aligned double
    14'b1_1_1_10_100_00_0_000, // R3 aligned excl word
    14'b0_1_0_00_111_00_0_000, // R4 byte at 7
    14'b1_1_1_00_011_00_0_000, // R4 excl byte at 3
    14'b0_0_1_10_010_10_0_011, // R5 excl word at 2
    14'b1_0_1_01_001_10_0_011, // R5 excl half at 1, u=1
    14'b1_1_1_11_100_10_0_011, // R5 excl double at 4
    14'b1_0_0_10_001_01_0_001, // R6 word at 1
    14'b1_1_0_01_011_01_0_001, // R6 half at 3
    14'b0_1_0_10_010_10_0_010, // R7 word at 2
    14'b0_1_0_01_101_10_0_010, // R7 half at 5
    14'b0_0_0_10_011_00_0_000, // R8 word at 3
    14'b0_0_0_01_001_00_0_000, // R8 half at 1
    14'b0_1_0_11_100_10_0_010, // R9 double at 4, u=0
    14'b1_1_0_11_010_10_0_010, // R9 double at 2, u=1
    14'b0_0_0_11_100_00_1_100, // R10 double at 4, u=0
    14'b1_0_0_11_001_00_1_100, // R10 double at 1, u=1
    14'b1_0_1_10_000_00_0_000  // R3 aligned excl word, u=1
  };
  localparam int VEC_REQ [NV] = '{3,3,4,4,5,5,5,6,6,7,7,8,8,9,9,10,10,3};

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              valid_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [1:0]        size_i = '0;
  logic              excl_i = 1'b0;
  logic              mode_u_i = 1'b0;
  logic              strict_a_i = 1'b0;
  logic              res_valid_o;
  logic [1:0]        res_verdict_o;
  logic              res_unpred_o;
  logic [2:0]        res_cause_o;
  int                checks = 0;
  int                errors = 0;
  bit                done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  align_chk #(.ADDR_W(ADDR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .addr_i(addr_i),
    .size_i(size_i), .excl_i(excl_i), .mode_u_i(mode_u_i), .strict_a_i(strict_a_i),
    .res_valid_o(res_valid_o), .res_verdict_o(res_verdict_o),
    .res_unpred_o(res_unpred_o), .res_cause_o(res_cause_o)
  );

  task automatic chk(input int req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual %b expected %b (valid,verdict,unpred,cause)", req, act, exp);
    end
  endtask

  task automatic drive(input logic [13:0] v, input logic [ADDR_W-4:0] hi);
    valid_i    = 1'b1;
    mode_u_i   = v[13];
    strict_a_i = v[12];
    excl_i     = v[11];
    size_i     = v[10:9];
    addr_i     = {hi, v[8:6]};
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(1, {res_valid_o, 6'b0}, 7'b0); // R1 in reset
    rst_ni = 1'b1;
    @(negedge clk);
    chk(1, {res_valid_o, 6'b0}, 7'b0); // R1 after reset, idle

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i], ADDR_W'($urandom) >> 3);
      @(negedge clk);
      chk(VEC_REQ[i], {res_valid_o, res_verdict_o, res_unpred_o, res_cause_o},
          {1'b1, VEC[i][5:0]});
    end

    // R2: no request gives no result
    valid_i = 1'b0;
    @(negedge clk);
    chk(2, {res_valid_o, 6'b0}, 7'b0);

    // R11: same low bits, different high bits
    drive(14'b0_1_0_10_010_10_0_010, '1);
    @(negedge clk);
    chk(11, {res_valid_o, res_verdict_o, res_unpred_o, res_cause_o}, 7'b1_10_0_010);
    drive(14'b0_1_0_10_000_00_0_000, '1);
    @(negedge clk);
    chk(11, {res_valid_o, res_verdict_o, res_unpred_o, res_cause_o}, 7'b1_00_0_000);

    // R2: back-to-back requests, then reset mid-stream (R1)
    drive(14'b1_0_0_01_001_01_0_001, 29'h1);
    @(negedge clk);
    chk(2, {res_valid_o, res_verdict_o, res_unpred_o, res_cause_o}, 7'b1_01_0_001);
    rst_ni = 1'b0;
    @(negedge clk);
    chk(1, {res_valid_o, 6'b0}, 7'b0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 2000 && !done; c++) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 actual timeout expected completion");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule